// File: doc/BRIEF.md
# Single-frame receive buffer with byte-wide host drain

This block sits between a network receiver and a host register port. The receiver hands over one Ethernet frame at a time as a byte stream marked with start, valid and last flags. The block stores that frame in an on-chip byte memory. The host then empties it one byte per read of a data port. A count register always shows how many stored bytes are still unread, because every data-port read lowers it by one.

Only one frame is held. A new frame is taken only when the shared busy flag, owned by the neighbouring interrupt/status unit, is low and the stored frame has not filled the whole buffer. When a frame has been stored, the block emits a one-cycle receive-done event, which that unit uses to raise busy. A frame that arrives while acceptance is refused is thrown away in full, up to its last byte.

Host reads take effect at the clock edge on which the read strobe is sampled. The returned word appears one cycle later, together with a valid flag.

Top module: `rx_frame_buf`

## Requirements
- R1: After reset, `rx_done`, `host_rvalid` and `net_ready` are low, and the count register reads 0.
- R2: A frame whose start byte arrives while `net_ready` is low, for example because `busy_in` was high in the previous cycle, is not stored and produces no `rx_done`.
- R3: While the remaining count equals the capacity (1514 bytes), `net_ready` stays low and a new frame is refused, even with `busy_in` low.
- R4: An accepted frame produces exactly one `rx_done` pulse, in the cycle after its last byte. The count register then holds the frame length, and the next data read returns the frame's first byte.
- R5: Each data-port read (address 0x1C) with a non-zero count returns the next stored byte in arrival order, zero-extended to 32 bits, and lowers the count (address 0x0C) by one.
- R6: A data-port read with a count of zero returns 0 and leaves the count at 0.
- R7: The count register is read-only. A write strobe to any address changes no state, and a cycle with both strobes is treated as a write, so no read is performed.
- R8: A refused frame is discarded up to and including its last byte, even if acceptance becomes possible while it is still arriving. A frame already stored is left intact, and the next frame after the refused one is stored normally.
- R9: A frame longer than the capacity keeps its first 1514 bytes, and the count is set to 1514.
- R10: `net_ready` goes low one cycle after `busy_in` is high, and it is low in the cycle after the last byte of an accepted frame.
- R11: A read strobe is answered by `host_rvalid` one cycle later. A read of an address that is neither the count nor the data port returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| net_valid | input | 1 | Network byte is present this cycle |
| net_sof | input | 1 | Marks the first byte of a frame |
| net_eof | input | 1 | Marks the last byte of a frame |
| net_data | input | 8 | Network byte |
| net_ready | output | 1 | A frame starting now would be accepted |
| busy_in | input | 1 | Shared busy flag from the interrupt/status unit |
| rx_done | output | 1 | One-cycle pulse when a frame has been stored |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe (no writable register exists) |
| host_addr | input | 6 | Host register address |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |

## Verification
The bench sends frames of random length, from a single byte up to 64 bytes, filled with random bytes. Some are sent back to back and some with idle gaps inside the frame. Reading every byte back and watching the count separates correct addressing and count-down from off-by-one pointer or length faults. Directed frames cover the remaining cases: a frame refused under busy on top of a half-read frame, a refused frame during which busy drops, a full 1514-byte frame that then blocks intake with busy low, and a 1520-byte frame. These show whether refusal, whole-frame dropping, the full-buffer gate and truncation are each handled separately, or whether they are merged into one condition.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int unsigned BUS_W = 32;

  typedef enum logic [1:0] {
    ING_IDLE,
    ING_FILL,
    ING_SKIP
  } ing_state_t;

  typedef enum logic [1:0] {
    RK_NONE,
    RK_COUNT,
    RK_BYTE
  } rd_kind_t;
endpackage

// File: rtl/rxb_store.sv
// Byte memory for one frame: one write port, one registered read port.
module rxb_store #(
  parameter int unsigned DEPTH = 1514,
  parameter int unsigned AW    = 11,
  parameter int unsigned DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxb_ingress.sv
// Frame intake: decides acceptance at the start byte, fills or skips the frame.
module rxb_ingress
  import rxb_pkg::*;
#(
  parameter int unsigned CAP = 1514,
  parameter int unsigned CW  = 11,
  parameter int unsigned AW  = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy_in,
  input  logic          cnt_full,
  input  logic          net_valid,
  input  logic          net_sof,
  input  logic          net_eof,
  input  logic [7:0]    net_data,
  output logic          net_ready,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wdata,
  output logic          done,
  output logic [CW-1:0] done_len
);
  ing_state_t    st;
  logic [CW-1:0] wptr;
  logic          ready_q;
  logic          done_q;
  logic [CW-1:0] len_q;

  logic          start, take, room, fill_byte, ending;
  logic [CW-1:0] end_len;

  assign start     = (st == ING_IDLE) && net_valid && net_sof;
  assign take      = start && ready_q;
  assign room      = (wptr < CW'(CAP));
  assign fill_byte = (st == ING_FILL) && net_valid;
  assign ending    = (take || fill_byte) && net_eof;
  assign end_len   = take ? CW'(1) : (room ? wptr + CW'(1) : CW'(CAP));

  assign we    = take || (fill_byte && room);
  assign waddr = take ? '0 : wptr[AW-1:0];
  assign wdata = net_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ING_IDLE;
      wptr    <= '0;
      ready_q <= 1'b0;
      done_q  <= 1'b0;
      len_q   <= '0;
    end else begin
      done_q  <= ending;
      if (ending) len_q <= end_len;
      // Hold off intake from the last byte until busy is seen by the next cycle.
      ready_q <= !busy_in && !cnt_full && !ending && !done_q;
      case (st)
        ING_IDLE: begin
          if (start) begin
            if (ready_q) begin
              if (!net_eof) begin
                st   <= ING_FILL;
                wptr <= CW'(1);
              end
            end else if (!net_eof) begin
              st <= ING_SKIP;
            end
          end
        end
        ING_FILL: begin
          if (net_valid) begin
            if (net_eof) begin
              st   <= ING_IDLE;
              wptr <= '0;
            end else if (room) begin
              wptr <= wptr + CW'(1);
            end
          end
        end
        ING_SKIP: begin
          if (net_valid && net_eof) st <= ING_IDLE;
        end
        default: st <= ING_IDLE;
      endcase
    end
  end

  assign net_ready = ready_q;
  assign done      = done_q;
  assign done_len  = len_q;

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  p_ready_busy_r10: assert property (@(posedge clk) disable iff (rst)
    busy_in |=> !ready_q);
  p_refuse_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !ready_q) |=> !done_q);
  p_fill_bound_r9: assert property (@(posedge clk) disable iff (rst)
    wptr <= CW'(CAP));
endmodule

// File: rtl/rxb_drain.sv
// Host side: remaining count, read pointer and read-data mux.
module rxb_drain
  import rxb_pkg::*;
#(
  parameter int unsigned          CAP       = 1514,
  parameter int unsigned          CW        = 11,
  parameter int unsigned          AW        = 11,
  parameter int unsigned          ADDR_W    = 6,
  parameter logic [ADDR_W-1:0]    CNT_ADDR  = 'h0C,
  parameter logic [ADDR_W-1:0]    DATA_ADDR = 'h1C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic             load,
  input  logic [CW-1:0]    load_len,
  input  logic [7:0]       byte_in,
  output logic             re,
  output logic [AW-1:0]    raddr,
  output logic             cnt_full,
  output logic [BUS_W-1:0] host_rdata,
  output logic             host_rvalid
);
  logic [CW-1:0] cnt;
  logic [AW-1:0] rptr;
  logic [CW-1:0] snap;
  rd_kind_t      kind;
  logic          rvalid_q;
  logic          rd_ok, hit_cnt, hit_data, has;

  assign rd_ok    = host_rd && !host_wr;
  assign hit_cnt  = rd_ok && (host_addr == CNT_ADDR);
  assign hit_data = rd_ok && (host_addr == DATA_ADDR);
  assign has      = (cnt != '0);
  assign re       = hit_data && has && !load;
  assign raddr    = rptr;
  assign cnt_full = (cnt >= CW'(CAP));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      rptr     <= '0;
      snap     <= '0;
      kind     <= RK_NONE;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_ok;
      if (rd_ok) begin
        snap <= cnt;
        if (hit_cnt)  kind <= RK_COUNT;
        else if (re)  kind <= RK_BYTE;
        else          kind <= RK_NONE;
      end
      if (load) begin
        cnt  <= load_len;
        rptr <= '0;
      end else if (re) begin
        cnt  <= cnt - CW'(1);
        rptr <= rptr + AW'(1);
      end
    end
  end

  always_comb begin
    case (kind)
      RK_BYTE:  host_rdata = {{(BUS_W-8){1'b0}}, byte_in};
      RK_COUNT: host_rdata = {{(BUS_W-CW){1'b0}}, snap};
      default:  host_rdata = '0;
    endcase
  end
  assign host_rvalid = rvalid_q;

  p_cnt_step_r5: assert property (@(posedge clk) disable iff (rst)
    (hit_data && has && !load) |=> (cnt == $past(cnt) - CW'(1)));
  p_zero_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (hit_data && !has && !load) |=> (cnt == '0) && (host_rdata == '0));
  p_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    (!load && !hit_data) |=> $stable(cnt));
  p_ptr_home_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> (rptr == '0));
  p_rvalid_r11: assert property (@(posedge clk) disable iff (rst)
    rd_ok |=> host_rvalid);
endmodule

// File: rtl/rx_frame_buf.sv
module rx_frame_buf
  import rxb_pkg::*;
#(
  parameter int unsigned       CAP       = 1514,
  parameter int unsigned       ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] CNT_ADDR  = 'h0C,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h1C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              net_valid,
  input  logic              net_sof,
  input  logic              net_eof,
  input  logic [7:0]        net_data,
  output logic              net_ready,
  input  logic              busy_in,
  output logic              rx_done,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [BUS_W-1:0]  host_rdata,
  output logic              host_rvalid
);
  localparam int unsigned AW = $clog2(CAP);
  localparam int unsigned CW = $clog2(CAP + 1);

  logic          we, re, cnt_full;
  logic [AW-1:0] waddr, raddr;
  logic [7:0]    wdata, rbyte;
  logic [CW-1:0] done_len;

  rxb_ingress #(.CAP(CAP), .CW(CW), .AW(AW)) u_ingress (
    .clk(clk), .rst(rst), .busy_in(busy_in), .cnt_full(cnt_full),
    .net_valid(net_valid), .net_sof(net_sof), .net_eof(net_eof),
    .net_data(net_data), .net_ready(net_ready), .we(we), .waddr(waddr),
    .wdata(wdata), .done(rx_done), .done_len(done_len)
  );

  rxb_store #(.DEPTH(CAP), .AW(AW), .DW(8)) u_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .re(re), .raddr(raddr), .rdata(rbyte)
  );

  rxb_drain #(
    .CAP(CAP), .CW(CW), .AW(AW), .ADDR_W(ADDR_W),
    .CNT_ADDR(CNT_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_drain (
    .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .load(rx_done), .load_len(done_len),
    .byte_in(rbyte), .re(re), .raddr(raddr), .cnt_full(cnt_full),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );
endmodule

// File: tb/sim_rx_frame_buf.sv
module sim_rx_frame_buf;
  localparam int CAP = 1514;
  localparam logic [5:0] CNT_A  = 6'h0C;
  localparam logic [5:0] DATA_A = 6'h1C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        net_valid = 0, net_sof = 0, net_eof = 0;
  logic [7:0]  net_data = 0;
  logic        busy_in = 0;
  logic        host_rd = 0, host_wr = 0;
  logic [5:0]  host_addr = 0;
  logic        net_ready, rx_done, host_rvalid;
  logic [31:0] host_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_mem [0:2047];
  logic [7:0] tx [0:2047];
  int exp_cnt = 0;
  int exp_rp  = 0;

  always #5 clk = ~clk;

  rx_frame_buf u0 (
    .clk(clk), .rst(rst), .net_valid(net_valid), .net_sof(net_sof),
    .net_eof(net_eof), .net_data(net_data), .net_ready(net_ready),
    .busy_in(busy_in), .rx_done(rx_done), .host_rd(host_rd),
    .host_wr(host_wr), .host_addr(host_addr), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid)
  );

  function automatic int stored_len(input int len);
    return (len > CAP) ? CAP : len;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic host_read(input logic [5:0] a, output int v, output bit vld);
    @(negedge clk);
    host_rd = 1; host_addr = a;
    @(negedge clk);
    host_rd = 0;
    v = host_rdata; vld = host_rvalid;
  endtask

  task automatic host_write(input logic [5:0] a);
    @(negedge clk);
    host_wr = 1; host_addr = a;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic check_count(input int expv, input string tag);
    int v; bit vld;
    host_read(CNT_A, v, vld);
    chk(vld && v == expv, tag, v, expv);
  endtask

  task automatic drain(input int n, input string tag);
    int v; bit vld;
    for (int k = 0; k < n; k++) begin
      host_read(DATA_A, v, vld);
      chk(vld && v == int'(exp_mem[exp_rp]), tag, v, int'(exp_mem[exp_rp]));
      exp_rp++; exp_cnt--;
    end
  endtask

  task automatic open_gate();
    busy_in = 0;
    repeat (2) @(negedge clk);
  endtask

  // Sends len bytes; expect_ok tells whether the block should take the frame.
  task automatic send_frame(input int len, input bit gaps, input bit expect_ok,
                            input bit drop_busy_mid, input string tag);
    for (int i = 0; i < len; i++) tx[i] = 8'($urandom);
    for (int i = 0; i < len; i++) begin
      if (gaps && i > 0 && ($urandom % 4) == 0) begin
        @(negedge clk);
        net_valid = 0; net_sof = 0; net_eof = 0;
      end
      @(negedge clk);
      net_valid = 1; net_sof = (i == 0); net_eof = (i == len - 1);
      net_data = tx[i];
      if (drop_busy_mid && i == 1) busy_in = 0;
    end
    @(negedge clk);
    net_valid = 0; net_sof = 0; net_eof = 0;
    chk(rx_done == expect_ok, {tag, " done"}, rx_done, expect_ok);
    if (expect_ok) begin
      chk(!net_ready, "R10 ready low after frame", net_ready, 0);
      busy_in = 1;
      exp_cnt = stored_len(len); exp_rp = 0;
      for (int i = 0; i < exp_cnt; i++) exp_mem[i] = tx[i];
    end
    @(negedge clk);
    chk(!rx_done, {tag, " single pulse"}, rx_done, 0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v; bit vld; int len;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(!rx_done && !host_rvalid && !net_ready, "R1 reset outputs", rx_done, 0);
    rst = 0;
    repeat (2) @(negedge clk);
    chk(net_ready, "R10 ready when idle", net_ready, 1);
    check_count(0, "R1 count after reset");
    host_read(DATA_A, v, vld);
    chk(vld && v == 0, "R6 empty data read", v, 0);
    check_count(0, "R6 count stays zero");
    host_read(6'h00, v, vld);
    chk(vld && v == 0, "R11 unknown address", v, 0);

    for (int k = 0; k < 8; k++) begin
      open_gate();
      len = (k == 0) ? 1 : 1 + int'($urandom % 64);
      send_frame(len, k[0], 1'b1, 1'b0, "R4 random frame");
      check_count(len, "R4 count loaded");
      host_write(CNT_A);
      check_count(len, "R7 write ignored");
      @(negedge clk);
      host_rd = 1; host_wr = 1; host_addr = DATA_A;
      @(negedge clk);
      host_rd = 0; host_wr = 0;
      check_count(len, "R7 rd+wr is a write");
      drain(len / 2, "R5 byte order");
      check_count(exp_cnt, "R5 count down");
      drain(exp_cnt, "R5 byte order tail");
      host_read(DATA_A, v, vld);
      chk(vld && v == 0, "R6 read past end", v, 0);
      check_count(0, "R6 count zero");
    end

    // refusal under busy on top of a half-read frame
    open_gate();
    send_frame(20, 1'b0, 1'b1, 1'b0, "R4 frame A");
    drain(5, "R5 frame A head");
    repeat (2) @(negedge clk);
    chk(!net_ready, "R10 ready low under busy", net_ready, 0);
    send_frame(10, 1'b0, 1'b0, 1'b0, "R2 refused under busy");
    check_count(15, "R8 stored frame kept");
    drain(15, "R8 stored bytes intact");

    // busy drops while a refused frame is still arriving
    busy_in = 1;
    repeat (2) @(negedge clk);
    send_frame(8, 1'b0, 1'b0, 1'b1, "R8 skip whole frame");
    check_count(0, "R8 nothing stored");
    open_gate();
    send_frame(12, 1'b1, 1'b1, 1'b0, "R8 next frame");
    check_count(12, "R8 next count");
    drain(12, "R8 next bytes");

    // full buffer blocks intake with busy low
    open_gate();
    send_frame(CAP, 1'b0, 1'b1, 1'b0, "R4 full frame");
    check_count(CAP, "R3 count full");
    open_gate();
    chk(!net_ready, "R3 ready low when full", net_ready, 0);
    send_frame(5, 1'b0, 1'b0, 1'b0, "R3 refused when full");
    check_count(CAP, "R3 full frame kept");
    drain(CAP, "R5 full frame bytes");
    open_gate();
    chk(net_ready, "R3 ready after drain", net_ready, 1);
    send_frame(4, 1'b0, 1'b1, 1'b0, "R3 accepted after drain");
    drain(4, "R5 small frame");

    // oversize frame
    open_gate();
    send_frame(CAP + 6, 1'b0, 1'b1, 1'b0, "R9 oversize frame");
    check_count(CAP, "R9 count clipped");
    drain(CAP, "R9 kept bytes");
    host_read(DATA_A, v, vld);
    chk(vld && v == 0, "R9 no extra bytes", v, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule